// File: doc/BRIEF.md
# Compact 32-bit Single-Cycle Processor Core

This core fetches, decodes and executes one instruction every clock. It has eight 32-bit general registers. Register 0 always reads as zero. There are four instruction classes: a register-to-register ALU class with six operations, a word load, a word store, and a branch taken on equality. The program memory and the data memory are small on-chip arrays. A preload port writes either array while reset is held, so a program and its starting data are in place before execution begins.

The outputs show the fetched word and the program counter. They also show the register write and the memory store that the current instruction will commit on the next rising edge. A surrounding environment can therefore follow execution without reaching inside the core.

Instruction fields:

- 31:29 holds the class. `000` is ALU, `001` is load, `010` is store and `011` is branch. Codes `100` to `111` do nothing.
- 28:26 holds the destination register.
- 25:23 holds the first source register.
- 22:20 holds the second source register.
- 19:17 holds the ALU function.
- 15:0 holds a signed immediate.

Top module: `mini_cpu32`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter and registers 1 to 7 become zero. While `rst` is high, no register write and no store is signalled.
- R2: An ALU instruction writes the destination register with a 32-bit result that wraps on overflow. Function `000` adds, `001` subtracts the second source from the first, `010` is OR, `011` is XOR and `100` is AND.
- R3: ALU function `101` (compare) writes 1 when the first source is less than the second as signed numbers, and writes 0 otherwise.
- R4: ALU functions `110` and `111` write the value zero to the destination register.
- R5: A load reads the data word at address (first source + sign-extended immediate), taken modulo the memory depth, and writes it to the destination register. The register is written on the same edge that advances the program counter.
- R6: A store writes the second source register to the data word at (first source + sign-extended immediate), modulo the depth. A store signals no register write.
- R7: A branch whose two sources are equal sets the program counter to PC + 1 + sign-extended immediate. This covers both forward and backward offsets.
- R8: Every other instruction advances the program counter by one. This includes a branch with unequal sources and the class codes `100` to `111`, which make no register write and no store.
- R9: Register 0 reads as zero. A write aimed at register 0 is dropped and `rf_we` stays low.
- R10: The preload port writes the program array (`ld_dmem`=0) or the data array (`ld_dmem`=1) at `ld_addr`. Instructions are fetched from the low address bits of the 32-bit program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 0 program array, 1 data array |
| ld_addr | input | MEM_AW | Preload word address |
| ld_wdata | input | 32 | Preload word |
| pc | output | 32 | Program counter (word address) |
| instr | output | 32 | Instruction word at `pc` |
| rf_we | output | 1 | Register write committed at the next edge |
| rf_waddr | output | 3 | Destination register |
| rf_wdata | output | 32 | Value written to the destination register |
| dm_we | output | 1 | Store committed at the next edge |
| dm_addr | output | 32 | Effective word address of a load or store |
| dm_wdata | output | 32 | Store data |

## Verification
The assertions assume that the preload port is used only while `rst` is high. They also assume that the first cycle after reset fetches a word the environment has already written, so every class field they decode is defined. The stimulus writes every word of both arrays during reset and only then releases it. Execution ends in a branch to itself, so after the end of the program the core keeps fetching known words.

// File: rtl/mini_cpu32.sv
module mini_cpu32 #(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic              ld_dmem,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [31:0]       ld_wdata,
  output logic [31:0]       pc,
  output logic [31:0]       instr,
  output logic              rf_we,
  output logic [2:0]        rf_waddr,
  output logic [31:0]       rf_wdata,
  output logic              dm_we,
  output logic [31:0]       dm_addr,
  output logic [31:0]       dm_wdata
);
  localparam int DEPTH = 1 << MEM_AW;

  localparam logic [2:0] C_ALU = 3'b000;
  localparam logic [2:0] C_LD  = 3'b001;
  localparam logic [2:0] C_ST  = 3'b010;
  localparam logic [2:0] C_BR  = 3'b011;

  logic [31:0] imem [DEPTH];
  logic [31:0] dmem [DEPTH];
  logic [31:0] regs [8];

  logic [2:0]  opc, rd, rs, rt, fn;
  logic [31:0] imm, a, b, alu_y;
  logic        taken;

  assign instr = imem[pc[MEM_AW-1:0]];
  assign opc   = instr[31:29];
  assign rd    = instr[28:26];
  assign rs    = instr[25:23];
  assign rt    = instr[22:20];
  assign fn    = instr[19:17];
  assign imm   = {{16{instr[15]}}, instr[15:0]};

  assign a = (rs == 3'd0) ? 32'd0 : regs[rs];
  assign b = (rt == 3'd0) ? 32'd0 : regs[rt];

  always_comb begin
    case (fn)
      3'd0:    alu_y = a + b;
      3'd1:    alu_y = a - b;
      3'd2:    alu_y = a | b;
      3'd3:    alu_y = a ^ b;
      3'd4:    alu_y = a & b;
      3'd5:    alu_y = {31'd0, $signed(a) < $signed(b)};
      default: alu_y = 32'd0;
    endcase
  end

  assign dm_addr  = a + imm;
  assign dm_wdata = b;
  assign dm_we    = !rst && opc == C_ST;
  assign rf_waddr = rd;
  assign rf_we    = !rst && (opc == C_ALU || opc == C_LD) && rd != 3'd0;
  assign rf_wdata = (opc == C_LD) ? dmem[dm_addr[MEM_AW-1:0]] : alu_y;
  assign taken    = opc == C_BR && a == b;

  always_ff @(posedge clk)
    if (ld_we && !ld_dmem) imem[ld_addr] <= ld_wdata;

  always_ff @(posedge clk) begin
    if (ld_we && ld_dmem)
      dmem[ld_addr] <= ld_wdata;
    else if (dm_we)
      dmem[dm_addr[MEM_AW-1:0]] <= dm_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= 32'd0;
      for (int i = 0; i < 8; i++) regs[i] <= 32'd0;
    end else begin
      pc <= pc + 32'd1 + (taken ? imm : 32'd0);
      if (rf_we) regs[rd] <= rf_wdata;
    end
  end

  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> pc == 32'd0);

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    opc != C_BR |=> pc == $past(pc) + 32'd1);

  // R6
  store_excl_chk: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> !rf_we);

  // R3
  cmp_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == C_ALU && fn == 3'd5 && rf_we) |-> rf_wdata[31:1] == 31'd0);

  // R9
  zero_src_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == C_ALU && fn == 3'd0 && rs == 3'd0 && rt == 3'd0 && rf_we) |-> rf_wdata == 32'd0);
endmodule

// File: tb/test_mini_cpu32.sv
module test_mini_cpu32;
  localparam int AW = 6;
  localparam int N  = 1 << AW;

  logic clk = 0, rst = 1, ld_we = 0, ld_dmem = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0] ld_wdata = '0;
  logic [31:0] pc, instr, rf_wdata, dm_addr, dm_wdata;
  logic rf_we, dm_we;
  logic [2:0] rf_waddr;

  always #2 clk = ~clk;

  mini_cpu32 #(.MEM_AW(AW)) i_mini_cpu32 (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
    .ld_wdata(ld_wdata), .pc(pc), .instr(instr), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] im [N];
  logic [31:0] dm [N];
  logic [31:0] rg [8];
  logic [31:0] mpc;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (pc=%0d)", req, act, exp, mpc);
    end
  endtask

  function automatic logic [31:0] e_alu(input int f, input int rd, input int rs, input int rt);
    return {3'b000, 3'(rd), 3'(rs), 3'(rt), 3'(f), 17'd0};
  endfunction
  function automatic logic [31:0] e_mem(input int op, input int rd, input int rs, input int rt, input int off);
    return {3'(op), 3'(rd), 3'(rs), 3'(rt), 4'd0, 16'(off)};
  endfunction

  function automatic logic [31:0] ref_alu(input int f, input logic [31:0] x, input logic [31:0] y);
    case (f)
      0: return x + y;
      1: return x - y;
      2: return x | y;
      3: return x ^ y;
      4: return x & y;
      5: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic step();
    logic [31:0] w, a, b, im_x, ea, res;
    logic [2:0] op, rd, rs, rt, fn;
    string tag;
    bit tk;
    w = im[mpc[AW-1:0]];
    op = w[31:29]; rd = w[28:26]; rs = w[25:23]; rt = w[22:20]; fn = w[19:17];
    im_x = {{16{w[15]}}, w[15:0]};
    a = rg[rs]; b = rg[rt];
    ea = a + im_x;
    tk = (op == 3'b011) && (a == b);
    if (op == 3'b000) tag = (fn < 5) ? "R2" : (fn == 5) ? "R3" : "R4";
    else if (op == 3'b001) tag = "R5";
    else if (op == 3'b010) tag = "R6";
    else if (tk) tag = "R7";
    else tag = "R8";
    if ((op == 3'b000 || op == 3'b001) && rd == 0) tag = "R9";
    chk("R10", instr, w);
    chk(tag, pc, mpc);
    res = (op == 3'b001) ? dm[ea[AW-1:0]] : ref_alu(int'(fn), a, b);
    if ((op == 3'b000 || op == 3'b001) && rd != 0) begin
      chk(tag, {31'd0, rf_we}, 32'd1);
      chk(tag, {29'd0, rf_waddr}, {29'd0, rd});
      chk(tag, rf_wdata, res);
      rg[rd] = res;
    end else
      chk(tag, {31'd0, rf_we}, 32'd0);
    chk(tag, {31'd0, dm_we}, {31'd0, op == 3'b010});
    if (op == 3'b010) begin
      chk("R6", dm_addr, ea);
      chk("R6", dm_wdata, b);
      dm[ea[AW-1:0]] = b;
    end
    mpc = mpc + 32'd1 + (tk ? im_x : 32'd0);
  endtask

  initial begin
    int a;
    for (int i = 0; i < N; i++) im[i] = e_alu(0, 0, 0, 0);
    for (int i = 0; i < N; i++) dm[i] = (32'(i) * 32'h9E3779B9) ^ (32'(i) << 5);
    dm[1] = 32'h8000_0000; dm[2] = 32'h7FFF_FFFF; dm[3] = 32'hFFFF_FFFF; dm[4] = 32'h0000_0005;
    dm[5] = 32'h8000_0000; dm[6] = 32'hFFFF_FFFB;
    im[0] = e_alu(0, 1, 2, 3);                          // R1 registers start at zero
    for (int k = 1; k <= 7; k++) im[k] = e_mem(1, k, 0, 0, k);
    a = 8;
    for (int f = 0; f < 8; f++) begin
      im[a]   = e_alu(f, (f % 7) + 1, 1, 2);
      im[a+1] = e_alu(f, ((f + 3) % 7) + 1, 3, 4);
      im[a+2] = e_alu(f, ((f + 5) % 7) + 1, 5, 6);
      a += 3;
    end
    im[32] = e_mem(2, 0, 2, 6, 9);
    im[33] = e_mem(1, 4, 2, 0, 9);
    im[34] = e_mem(1, 5, 0, 0, -1);                     // wraps to last word
    im[35] = e_alu(0, 0, 1, 2);                          // R9 write to r0
    im[36] = e_alu(0, 3, 0, 0);
    im[37] = e_mem(3, 0, 1, 2, 5);
    im[38] = {3'b100, 29'h1FFF_FFFF};
    im[39] = {3'b111, 29'h0ABC_1234};
    im[40] = e_mem(3, 0, 0, 0, 3);
    im[41] = e_alu(0, 7, 1, 1);
    im[42] = e_alu(1, 6, 4, 5);
    im[43] = e_mem(3, 0, 0, 0, 2);
    im[44] = e_alu(3, 2, 4, 1);
    im[45] = e_mem(3, 0, 0, 0, -4);
    im[46] = e_mem(3, 0, 0, 0, -1);                     // self loop
    for (int i = 0; i < 8; i++) rg[i] = 32'd0;
    mpc = 32'd0;

    rst = 1;
    for (int i = 0; i < 2 * N; i++) begin
      @(negedge clk);
      ld_we = 1; ld_dmem = (i >= N); ld_addr = AW'(i % N);
      ld_wdata = (i >= N) ? dm[i - N] : im[i];
    end
    @(negedge clk);
    ld_we = 0;
    #1;
    chk("R1", pc, 32'd0);
    chk("R1", {30'd0, rf_we, dm_we}, 32'd0);
    chk("R10", instr, im[0]);
    @(negedge clk);
    rst = 0;
    #1;
    for (int c = 0; c < 120; c++) begin
      step();
      @(negedge clk);
      #1;
    end
    chk("R7", pc, 32'd46);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule